// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Path

This block gathers 32 level-sensitive interrupt lines for one processor core. It presents them to the core as an interrupt request wire with an 8-bit vector, plus a separate non-maskable request. The two highest lines form the non-maskable group. They skip the mask entirely and land in their own status word. The remaining lines are shifted down by one position into a raw status word. Software gates that word with a writable enable mask.

The vector names the single active source when only one masked source is pending. When two or more masked sources are pending at once, the block does not choose among them. It emits a shared "several pending" code, and software reads the masked status word to decide the order of service. There is no edge capture: every status bit and every output tracks the current line levels, one clock later.

Software sees five 32-bit words through a simple strobe bus with a byte address. Address bits above the lowest two select the word. Only the enable mask can be written.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the enable mask, raw status, masked status and non-maskable status all read zero, and `irq_req_o`, `nmi_req_o` and `irq_vec_o` are all 0.
- R2: A write with `wr_en_i` high and word index `addr_i[4:2]` = 0 loads `wr_data_i` into the enable mask. Reading word index 0 returns the mask.
- R3: A write to word indices 1 to 7 leaves the enable mask unchanged.
- R4: Raw status is read at word index 1. For n from 1 to 29, bit n-1 equals the level of line n. Line 0 has no effect on any status bit or output. Raw bits 29 to 31 are always 0.
- R5: Masked status is read at word index 2 and equals raw status AND enable mask.
- R6: When exactly one masked status bit i is set, `irq_req_o` is 1 and `irq_vec_o` = 0x31 + i.
- R7: When two or more masked status bits are set, `irq_req_o` is 1 and `irq_vec_o` = 0x30.
- R8: When no masked status bit is set, `irq_req_o` is 0 and `irq_vec_o` = 0.
- R9: Non-maskable status is read at word index 3. Its bits 30 and 31 follow lines 30 and 31, and its bits 0 to 29 are always 0. Lines 30 and 31 never affect raw status, masked status or the vector.
- R10: `nmi_req_o` is 1 exactly when any non-maskable status bit is set. The enable mask has no effect on it.
- R11: Word index 4 (the reserved word) and word indices 5 to 7 read as zero.
- R12: Status words and outputs take the line levels and mask value present at a rising clock edge, and they show the new values right after that edge. When `rd_en_i` is high at an edge, `rd_data_o` shows the addressed word as it stood before that edge; otherwise `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 32 | Interrupt line levels; lines 30 and 31 are non-maskable |
| addr_i | input | 5 | Byte address; bits 4:2 select the word |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Interrupt vector |
| nmi_req_o | output | 1 | Non-maskable interrupt request |

## Verification
Line levels and mask writes are both sampled at a rising edge, and the request, vector and status words all change on that same edge. The bench therefore drives every stimulus on a falling edge, waits through one rising edge, and compares the outputs on the next falling edge. At that point it has already updated its own mask, raw and non-maskable model words. Read data has a one-edge latency and shows the state from before the sampling edge, so the expected word for a read is taken from the model before that model is updated.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned VEC_W    = 8;
  localparam logic [VEC_W-1:0] VEC_MULTI = 8'h30;
  localparam logic [VEC_W-1:0] VEC_BASE  = 8'h31;

  typedef enum logic [2:0] {
    W_MASK   = 3'd0,
    W_RAW    = 3'd1,
    W_MASKED = 3'd2,
    W_NMI    = 3'd3,
    W_RSVD   = 3'd4
  } word_sel_e;

  // Vector code for a masked status word
  function automatic logic [VEC_W-1:0] vec_of(input logic [WORD_W-1:0] m);
    logic [VEC_W-1:0] v;
    v = '0;
    if ($countones(m) > 1) begin
      v = VEC_MULTI;
    end else begin
      for (int i = 0; i < WORD_W; i++) begin
        if (m[i]) v = VEC_BASE + VEC_W'(i);
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
  parameter int unsigned N_LINES   = 32,
  parameter int unsigned NMI_FIRST = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_i,
  output logic [N_LINES-1:0] raw_nx_o,
  output logic [N_LINES-1:0] nmi_nx_o,
  output logic [N_LINES-1:0] raw_q_o,
  output logic [N_LINES-1:0] nmi_q_o
);
  localparam int unsigned RAW_BITS = NMI_FIRST - 1;

  // Line n (1..NMI_FIRST-1) drives raw bit n-1; upper lines feed NMI status
  for (genvar j = 0; j < N_LINES; j++) begin : g_map
    if (j < RAW_BITS) begin : g_raw
      assign raw_nx_o[j] = lines_i[j+1];
    end else begin : g_raw_zero
      assign raw_nx_o[j] = 1'b0;
    end
    if (j >= NMI_FIRST) begin : g_nmi
      assign nmi_nx_o[j] = lines_i[j];
    end else begin : g_nmi_zero
      assign nmi_nx_o[j] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q_o <= '0;
      nmi_q_o <= '0;
    end else begin
      raw_q_o <= raw_nx_o;
      nmi_q_o <= nmi_nx_o;
    end
  end

  p_raw_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q_o[N_LINES-1:RAW_BITS] == '0);
  p_nmi_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> nmi_q_o[N_LINES-1:NMI_FIRST] == $past(lines_i[N_LINES-1:NMI_FIRST]));
  p_nmi_lower_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q_o[NMI_FIRST-1:0] == '0);
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_vec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] raw_q_i,
  input  logic [DATA_W-1:0] masked_q_i,
  input  logic [DATA_W-1:0] nmi_q_i,
  output logic [DATA_W-1:0] mask_nx_o,
  output logic [DATA_W-1:0] mask_q_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  word_idx;
  logic              mask_hit;
  logic [DATA_W-1:0] rd_word;

  assign word_idx  = addr_i[ADDR_W-1:2];
  assign mask_hit  = wr_en_i && (word_idx == IDX_W'(W_MASK));
  assign mask_nx_o = mask_hit ? wr_data_i : mask_q_o;

  always_comb begin
    case (word_idx)
      IDX_W'(W_MASK):   rd_word = mask_q_o;
      IDX_W'(W_RAW):    rd_word = raw_q_i;
      IDX_W'(W_MASKED): rd_word = masked_q_i;
      IDX_W'(W_NMI):    rd_word = nmi_q_i;
      default:          rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q_o  <= '0;
      rd_data_o <= '0;
    end else begin
      mask_q_o <= mask_nx_o;
      if (rd_en_i) rd_data_o <= rd_word;
    end
  end

  p_ro_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && word_idx != '0) |=> $stable(mask_q_o));
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && word_idx == '0) |=> mask_q_o == $past(wr_data_i));
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_vec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] raw_nx_i,
  input  logic [DATA_W-1:0] mask_nx_i,
  input  logic [DATA_W-1:0] nmi_nx_i,
  output logic [DATA_W-1:0] masked_q_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              nmi_req_o
);
  logic [DATA_W-1:0] masked_nx;
  logic [VEC_W-1:0]  vec_nx;

  assign masked_nx = raw_nx_i & mask_nx_i;
  assign vec_nx    = vec_of(WORD_W'(masked_nx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked_q_o <= '0;
      irq_req_o  <= 1'b0;
      irq_vec_o  <= '0;
      nmi_req_o  <= 1'b0;
    end else begin
      masked_q_o <= masked_nx;
      irq_req_o  <= |masked_nx;
      irq_vec_o  <= vec_nx;
      nmi_req_o  <= |nmi_nx_i;
    end
  end

  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(masked_nx) == 1) |=> (irq_req_o && irq_vec_o > VEC_MULTI));
  p_multi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(masked_nx) > 1) |=> (irq_req_o && irq_vec_o == VEC_MULTI));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_nx == '0) |=> (!irq_req_o && irq_vec_o == '0));
  p_nmi_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_nx_i != '0) |=> nmi_req_o);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_LINES   = 32,
  parameter int unsigned NMI_FIRST = 30,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [N_LINES-1:0] wr_data_i,
  input  logic               rd_en_i,
  output logic [N_LINES-1:0] rd_data_o,
  output logic               irq_req_o,
  output logic [VEC_W-1:0]   irq_vec_o,
  output logic               nmi_req_o
);
  logic [N_LINES-1:0] raw_nx, nmi_nx, raw_q, nmi_q;
  logic [N_LINES-1:0] mask_nx, mask_q, masked_q;

  irq_line_sampler #(.N_LINES(N_LINES), .NMI_FIRST(NMI_FIRST)) u_sampler (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_lines_i),
    .raw_nx_o(raw_nx), .nmi_nx_o(nmi_nx), .raw_q_o(raw_q), .nmi_q_o(nmi_q)
  );

  irq_mask_regs #(.DATA_W(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .raw_q_i(raw_q),
    .masked_q_i(masked_q), .nmi_q_i(nmi_q), .mask_nx_o(mask_nx),
    .mask_q_o(mask_q), .rd_data_o(rd_data_o)
  );

  irq_vector_gen #(.DATA_W(N_LINES)) u_vecgen (
    .clk(clk), .rst_n(rst_n), .raw_nx_i(raw_nx), .mask_nx_i(mask_nx),
    .nmi_nx_i(nmi_nx), .masked_q_o(masked_q), .irq_req_o(irq_req_o),
    .irq_vec_o(irq_vec_o), .nmi_req_o(nmi_req_o)
  );

  p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    masked_q == (raw_q & mask_q));
  p_nmi_agree_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req_o == (nmi_q != '0));
  p_irq_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o == (masked_q != '0));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        nmi_req;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_mask = '0, m_raw = '0, m_nmi = '0;

  always #4 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .irq_req_o(irq_req), .irq_vec_o(irq_vec),
    .nmi_req_o(nmi_req)
  );

  // Expected vector: count from the top, remember lowest set bit
  function automatic logic [7:0] exp_vec(input logic [31:0] m);
    int n = 0;
    int pos = 0;
    for (int k = 31; k >= 0; k--) if (m[k]) begin n++; pos = k; end
    if (n == 0) return 8'h00;
    if (n >= 2) return 8'h30;
    return 8'h31 + 8'(pos);
  endfunction

  function automatic logic [31:0] exp_word(input int idx);
    case (idx)
      0: return m_mask;
      1: return m_raw;
      2: return m_raw & m_mask;
      3: return m_nmi;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outs(input string req);
    logic [7:0] v;
    v = exp_vec(m_raw & m_mask);
    chk({req, " vec"}, 32'(irq_vec), 32'(v));
    chk({req, " irq"}, 32'(irq_req), 32'(v != 8'h00));
    chk({req, " nmi R10"}, 32'(nmi_req), 32'(m_nmi != 0));
  endtask

  // One cycle: drive at negedge, sample at next negedge
  task automatic step(input logic [31:0] l, input logic w, input logic [4:0] a,
                      input logic [31:0] d, input logic r, input string req);
    logic [31:0] rd_exp;
    lines = l; wr_en = w; addr = a; wr_data = d; rd_en = r;
    rd_exp = exp_word(int'(a[4:2]));
    @(posedge clk);
    if (w && a[4:2] == 3'd0) m_mask = d;
    m_raw = '0;
    for (int n = 1; n < 30; n++) m_raw[n-1] = l[n];
    m_nmi = '0;
    m_nmi[31:30] = l[31:30];
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check_outs(req);
    if (r) chk({req, " rd R12"}, rd_data, rd_exp);
  endtask

  task automatic read_all(input logic [31:0] l, input string req);
    for (int i = 0; i < 8; i++) step(l, 1'b0, 5'(i * 4), 32'h0, 1'b1, req);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq_req), 0);
    chk("R1 vec", 32'(irq_vec), 0);
    chk("R1 nmi", 32'(nmi_req), 0);
    read_all(32'h0, "R1 regs");

    // R2 mask write and readback
    step(32'h0, 1'b1, 5'h00, 32'hA5A5_0F0F, 1'b0, "R2 write");
    step(32'h0, 1'b0, 5'h00, 32'h0, 1'b1, "R2 read");
    // R3 writes elsewhere ignored
    for (int i = 1; i < 8; i++) step(32'h0, 1'b1, 5'(i * 4), 32'hFFFF_FFFF, 1'b0, "R3 write");
    step(32'h0, 1'b0, 5'h00, 32'h0, 1'b1, "R3 mask kept");

    step(32'h0, 1'b1, 5'h00, 32'hFFFF_FFFF, 1'b0, "R2 open mask");
    // R4 line 0 ignored, line n drives bit n-1
    step(32'h0000_0001, 1'b0, 5'h04, 32'h0, 1'b1, "R4 line0");
    step(32'h0000_0001, 1'b0, 5'h04, 32'h0, 1'b1, "R4 line0 raw");
    // R6 each single source; R4 readback
    for (int n = 1; n < 30; n++) begin
      step(32'(1) << n, 1'b0, 5'h04, 32'h0, 1'b0, "R6 single");
      step(32'(1) << n, 1'b0, 5'h04, 32'h0, 1'b1, "R4 raw bit");
    end
    // R7 two sources
    step(32'h0000_0006, 1'b0, 5'h08, 32'h0, 1'b0, "R7 pair");
    step(32'h2000_0002, 1'b0, 5'h08, 32'h0, 1'b1, "R7 extremes");
    // R9/R10: NMI lines, no effect on vector even with mask open
    step(32'h4000_0000, 1'b0, 5'h0C, 32'h0, 1'b0, "R9 line30");
    step(32'h8000_0000, 1'b0, 5'h0C, 32'h0, 1'b1, "R9 line31");
    step(32'hC000_0000, 1'b0, 5'h04, 32'h0, 1'b1, "R9 raw clear");
    step(32'hC000_0000, 1'b1, 5'h00, 32'h0, 1'b0, "R10 mask closed");
    step(32'hC000_0004, 1'b0, 5'h0C, 32'h0, 1'b1, "R10 nmi kept");
    step(32'h0000_0004, 1'b0, 5'h08, 32'h0, 1'b1, "R8 masked out");
    // R5 partial mask: single surviving bit
    step(32'h0000_0006, 1'b1, 5'h00, 32'h0000_0002, 1'b0, "R5 partial");
    step(32'h0000_0006, 1'b0, 5'h08, 32'h0, 1'b1, "R5 masked word");
    step(32'h0, 1'b0, 5'h10, 32'h0, 1'b1, "R8 idle R11");
    read_all(32'hFFFF_FFFF, "R11 all words");

    // Random: sparse lines, occasional mask writes, mixed reads
    for (int t = 0; t < 600; t++) begin
      l = $urandom(t + 17) & $urandom() & $urandom();
      if ($urandom_range(0, 3) == 0) l = 32'(1) << $urandom_range(0, 31);
      step(l, ($urandom_range(0, 7) == 0), 5'($urandom_range(0, 31)),
           $urandom() | $urandom(), ($urandom_range(0, 1) == 1), "R12 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule